// File: doc/BRIEF.md
# Linear Photodiode Array Readout Controller

This block sequences a 128-element linear light-sensor array and gathers one digitized sample per element. It derives a slow sensor clock from the system clock, issues the one-shot start token that the sensor shifts through its internal pixel chain, and walks the sensor through 129 rising edges per frame. After each of the first 128 edges it asks an external converter for a sample. When the converter returns one, it is forwarded as a beat on an indexed pixel stream.

Between frames the controller keeps the sensor idle for a programmable charge-transfer gap plus an optional integration wait. No new start token is issued until that window has elapsed. In single-shot mode a host pulses `start` while the block is idle and waits for `done` or for `busy` to fall. In continuous mode the next frame begins by itself once the window ends. The configuration inputs are read live and must be held steady while `busy` is high.

Top module: `lsa_readout`

## Requirements
- R1: While reset is held, and in the first cycles after its release, `sen_clk`, `sen_si`, `adc_start`, `pix_valid`, `done` and `busy` are all low.
- R2: With `cfg_half` = H (H of 2 or more), every high phase of `sen_clk` lasts exactly H system cycles. When no sample is pending, each low phase also lasts H cycles, so a rising edge comes H cycles after the frame begins or after the previous pixel beat.
- R3: `sen_si` rises floor(H/2) cycles after the frame's first low phase begins, which is H − floor(H/2) cycles before the first rising edge. It changes only while `sen_clk` is low. It is high at the first rising edge of a frame and low at every later one.
- R4: Every frame contains exactly 129 rising edges of `sen_clk`.
- R5: `adc_start` is a one-cycle pulse issued in the cycle `sen_clk` falls after rising edge k, for k from 1 to 128, which gives 128 pulses per frame. No pulse follows the 129th edge.
- R6: After an `adc_start`, `sen_clk` stays low until `adc_done` is seen. An `adc_done` that arrives while no sample is pending produces no pixel beat.
- R7: An `adc_done` accepted after edge k yields one `pix_valid` cycle on the next clock, with `pix_idx` = k−1 (7 bits, 0 to 127) and `pix_data` equal to the `adc_data` presented with `adc_done`.
- R8: `done` pulses for one cycle in the cycle `sen_clk` falls after the 129th rising edge, which is H cycles after that edge and after all 128 beats of the frame.
- R9: In continuous mode the next `sen_si` rise comes exactly H + (`cfg_gap` + `cfg_integ`) + 1 + floor(H/2) cycles after the previous frame's 129th rising edge.
- R10: In single-shot mode `busy` falls exactly H + (`cfg_gap` + `cfg_integ`) + 1 cycles after the 129th rising edge. A `start` pulse seen while `busy` is high is ignored and starts no frame.
- R11: In continuous mode frames follow one another automatically. Clearing `cfg_cont` before the inter-frame wait ends stops the sequence after the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_half | input | DIV_W (8) | System cycles per half period of the sensor clock (2 or more) |
| cfg_gap | input | GAP_W (12) | Minimum charge-transfer gap after the last edge, in system cycles |
| cfg_integ | input | GAP_W (12) | Extra integration wait added to the gap |
| cfg_cont | input | 1 | 1 = continuous frames, 0 = single shot |
| start | input | 1 | Frame request, accepted only while idle |
| busy | output | 1 | High from the accepted start until the inter-frame wait ends |
| done | output | 1 | One-cycle pulse at the end of each frame |
| sen_clk | output | 1 | Sensor pixel clock |
| sen_si | output | 1 | Sensor start token |
| adc_start | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Conversion result valid |
| adc_data | input | DATA_W (12) | Conversion result |
| pix_valid | output | 1 | Pixel beat valid |
| pix_idx | output | 7 | Pixel index, 0 to 127 |
| pix_data | output | DATA_W (12) | Pixel value |

## Verification
The bench sweeps the half period over the values 2 to 5, several gap and integration values, and converter latencies from zero to three cycles. It times every sensor-clock edge, token edge, request and beat against arithmetic expectations. An off-by-one frame length, such as 128 or 130 edges or a sample request after the final edge, shows up as a wrong per-frame count at `done`. A start token that spans two edges, or that changes while the clock is high, is caught at each rising edge. A gap counter that is one cycle short, or that ignores the integration wait, skews the measured restart and `busy` fall times. Spurious converter responses injected outside the wait, and a `start` pulsed mid-frame, would appear as extra beats or extra frames if the design accepted them.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ADC  = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/lsa_phase.sv
module lsa_phase #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             pclk,
  output logic             ev_rise,
  output logic             ev_mid,
  output logic             ev_wrap
);

  localparam int PH_W = DIV_W + 1;

  logic [PH_W-1:0] ph_q, ph_d;
  logic [PH_W-1:0] half_x, last_x, mid_x;
  logic            pclk_q, pclk_d;

  assign half_x = {1'b0, half};
  assign last_x = (half_x << 1) - PH_W'(1);
  assign mid_x  = {2'b00, half[DIV_W-1:1]};

  // events are seen one cycle before the phase value they announce
  assign ev_wrap = en && (ph_q == last_x);
  assign ev_rise = en && (ph_q == half_x - PH_W'(1));
  assign ev_mid  = en && (ph_q == mid_x - PH_W'(1));

  always_comb begin
    ph_d = ph_q;
    if (en) begin
      ph_d = ev_wrap ? '0 : ph_q + PH_W'(1);
    end
    pclk_d = (ph_d >= half_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      pclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pclk_q <= pclk_d;
    end
  end

  assign pclk = pclk_q;

  // R6
  stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pclk_q);

  // R2
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (ph_q <= last_x));

endmodule

// File: rtl/lsa_gap.sv
module lsa_gap #(
  parameter int GAP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [GAP_W-1:0] gap,
  input  logic [GAP_W-1:0] integ,
  output logic             zero
);

  localparam int CW = GAP_W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load || (dec && !zero);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = {1'b0, gap} + {1'b0, integ};
    end else if (dec && !zero) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lsa_seq.sv
module lsa_seq
  import lsa_pkg::*;
#(
  parameter int NPIX   = 128,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cont,
  input  logic              ev_rise,
  input  logic              ev_mid,
  input  logic              ev_wrap,
  input  logic              gap_zero,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              run_en,
  output logic              gap_load,
  output logic              gap_dec,
  output logic              si,
  output logic              adc_start,
  output logic              pix_valid,
  output logic [IDX_W-1:0]  pix_idx,
  output logic [DATA_W-1:0] pix_data,
  output logic              done,
  output logic              busy
);

  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(NPIX + 1);
  localparam logic [CNT_W-1:0] LAST_PIX  = CNT_W'(NPIX);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  edge_q, edge_d;
  logic              si_q, si_d;
  logic              adcs_q, adcs_d;
  logic              pv_q, pv_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              done_q, done_d;
  logic              beat_en;

  always_comb begin
    state_d  = state_q;
    edge_d   = edge_q;
    si_d     = si_q;
    adcs_d   = 1'b0;
    pv_d     = 1'b0;
    idx_d    = idx_q;
    data_d   = data_q;
    done_d   = 1'b0;
    gap_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          edge_d  = '0;
        end
      end
      ST_RUN: begin
        if (ev_rise) edge_d = edge_q + CNT_W'(1);
        if (ev_mid)  si_d   = (edge_q == '0);
        if (ev_wrap) begin
          if (edge_q == LAST_EDGE) begin
            state_d  = ST_GAP;
            done_d   = 1'b1;
            gap_load = 1'b1;
          end else begin
            state_d = ST_ADC;
            adcs_d  = 1'b1;
          end
        end
      end
      ST_ADC: begin
        if (adc_done) begin
          state_d = ST_RUN;
          pv_d    = 1'b1;
          idx_d   = IDX_W'(edge_q - CNT_W'(1));
          data_d  = adc_data;
        end
      end
      ST_GAP: begin
        if (gap_zero) begin
          if (cont) begin
            state_d = ST_RUN;
            edge_d  = '0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign beat_en = (state_q == ST_ADC) && adc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      si_q    <= 1'b0;
      adcs_q  <= 1'b0;
      pv_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      si_q    <= si_d;
      adcs_q  <= adcs_d;
      pv_q    <= pv_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      data_q <= '0;
    end else if (beat_en) begin
      idx_q  <= idx_d;
      data_q <= data_d;
    end
  end

  assign run_en    = (state_q == ST_RUN);
  assign gap_dec   = (state_q == ST_GAP);
  assign si        = si_q;
  assign adc_start = adcs_q;
  assign pix_valid = pv_q;
  assign pix_idx   = idx_q;
  assign pix_data  = data_q;
  assign done      = done_q;
  assign busy      = (state_q != ST_IDLE);

  // R3
  si_single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise && si_q) |-> (edge_q == '0));

  // R5
  adc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adcs_q |-> ((edge_q >= CNT_W'(1)) && (edge_q <= LAST_PIX)));

  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (edge_q == LAST_EDGE) && (state_q == ST_GAP));

  // R6
  beat_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> (state_q == ST_RUN) && !adcs_q);

endmodule

// File: rtl/lsa_readout.sv
module lsa_readout #(
  parameter int NPIX   = 128,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic [GAP_W-1:0]  cfg_integ,
  input  logic              cfg_cont,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              sen_clk,
  output logic              sen_si,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              pix_valid,
  output logic [$clog2(NPIX)-1:0] pix_idx,
  output logic [DATA_W-1:0] pix_data
);

  localparam int IDX_W = $clog2(NPIX);
  localparam int CNT_W = $clog2(NPIX + 2);

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       run_en, ev_rise, ev_mid, ev_wrap;
  logic       gap_load, gap_dec, gap_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  lsa_phase #(.DIV_W(DIV_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_ni),
    .en      (run_en),
    .half    (cfg_half),
    .pclk    (sen_clk),
    .ev_rise (ev_rise),
    .ev_mid  (ev_mid),
    .ev_wrap (ev_wrap)
  );

  lsa_gap #(.GAP_W(GAP_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_ni),
    .load  (gap_load),
    .dec   (gap_dec),
    .gap   (cfg_gap),
    .integ (cfg_integ),
    .zero  (gap_zero)
  );

  lsa_seq #(
    .NPIX   (NPIX),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .start     (start),
    .cont      (cfg_cont),
    .ev_rise   (ev_rise),
    .ev_mid    (ev_mid),
    .ev_wrap   (ev_wrap),
    .gap_zero  (gap_zero),
    .adc_done  (adc_done),
    .adc_data  (adc_data),
    .run_en    (run_en),
    .gap_load  (gap_load),
    .gap_dec   (gap_dec),
    .si        (sen_si),
    .adc_start (adc_start),
    .pix_valid (pix_valid),
    .pix_idx   (pix_idx),
    .pix_data  (pix_data),
    .done      (done),
    .busy      (busy)
  );

  // R3
  si_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sen_clk |-> $stable(sen_si));

  // R5
  no_sample_high_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    adc_start |-> !sen_clk);

endmodule

// File: tb/lsa_readout_test.sv
module lsa_readout_test;

  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 128;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_half;
  logic [11:0] cfg_gap, cfg_integ;
  logic        cfg_cont, start;
  logic        busy, done, sen_clk, sen_si, adc_start;
  logic        adc_done;
  logic [11:0] adc_data;
  logic        pix_valid;
  logic [6:0]  pix_idx;
  logic [11:0] pix_data;

  lsa_readout uut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_gap(cfg_gap),
    .cfg_integ(cfg_integ), .cfg_cont(cfg_cont), .start(start), .busy(busy),
    .done(done), .sen_clk(sen_clk), .sen_si(sen_si), .adc_start(adc_start),
    .adc_done(adc_done), .adc_data(adc_data), .pix_valid(pix_valid),
    .pix_idx(pix_idx), .pix_data(pix_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // bench-side timing state
  int cyc = 0;
  int H = 2, N = 0, lat = 0;
  bit spur_en = 0;
  bit p_clk = 0, p_si = 0, p_busy = 0;
  int si_rise_t = 0, high_t = 0, last_beat_t = 0, last_rise_t = 0;
  bit have_last = 0;
  int f_rises = 0, f_si = 0, f_starts = 0, f_beats = 0;
  int frames = 0, beat_total = 0;
  bit mon_pend = 0, hi_in_pend = 0;
  // converter model state
  bit adc_pend = 0;
  int adc_cnt = 0, served = 0, spur_t = 0;

  function automatic int adc_val(input int n);
    return (n * 29 + 7) % 4096;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic monitor();
    cyc++;
    if (sen_si && !p_si) begin
      si_rise_t = cyc;
      if (have_last)
        chk(cyc - last_rise_t == H + N + 1 + H/2, "R9", "restart delay",
            cyc - last_rise_t, H + N + 1 + H/2);
      have_last = 0;
    end
    if (sen_clk && !p_clk) begin
      f_rises++;
      if (f_rises == 1) begin
        chk(sen_si == 1'b1, "R3", "token at first edge", int'(sen_si), 1);
        chk(cyc - si_rise_t == H - H/2, "R3", "token lead", cyc - si_rise_t, H - H/2);
        f_si++;
      end else begin
        if (sen_si) f_si++;
        chk(cyc - last_beat_t == H, "R2", "low phase after beat",
            cyc - last_beat_t, H);
      end
      if (f_rises == NPIX + 1) begin
        last_rise_t = cyc;
        have_last = 1;
      end
      high_t = cyc;
    end
    if (!sen_clk && p_clk)
      chk(cyc - high_t == H, "R2", "high phase", cyc - high_t, H);
    if (mon_pend && sen_clk) hi_in_pend = 1;
    if (adc_start) begin
      f_starts++;
      chk(cyc - high_t == H && f_rises >= 1 && f_rises <= NPIX, "R5",
          "request placement", f_rises, f_starts);
      mon_pend = 1;
      hi_in_pend = 0;
    end
    if (pix_valid) begin
      chk(mon_pend && !hi_in_pend, "R6", "beat only after pending request",
          int'(mon_pend), 1);
      chk(int'(pix_idx) == f_beats, "R7", "pixel index", int'(pix_idx), f_beats);
      chk(int'(pix_data) == adc_val(beat_total), "R7", "pixel data",
          int'(pix_data), adc_val(beat_total));
      f_beats++;
      beat_total++;
      mon_pend = 0;
      last_beat_t = cyc;
    end
    if (done) begin
      chk(f_rises == NPIX + 1, "R4", "edges per frame", f_rises, NPIX + 1);
      chk(f_starts == NPIX, "R5", "requests per frame", f_starts, NPIX);
      chk(f_beats == NPIX, "R8", "beats before done", f_beats, NPIX);
      chk(f_si == 1, "R3", "edges seeing token", f_si, 1);
      chk(cyc - last_rise_t == H, "R8", "done timing", cyc - last_rise_t, H);
      frames++;
      f_rises = 0; f_si = 0; f_starts = 0; f_beats = 0;
    end
    if (!busy && p_busy && have_last) begin
      chk(cyc - last_rise_t == H + N + 1, "R10", "busy fall delay",
          cyc - last_rise_t, H + N + 1);
      have_last = 0;
    end
    p_clk = sen_clk; p_si = sen_si; p_busy = busy;
  endtask

  task automatic adc_model();
    adc_done = 1'b0;
    if (adc_pend) begin
      if (adc_cnt == 0) begin
        adc_done = 1'b1;
        adc_data = 12'(adc_val(served));
        served++;
        adc_pend = 0;
      end else begin
        adc_cnt--;
      end
    end else if (adc_start) begin
      adc_pend = 1;
      adc_cnt = lat;
    end else if (spur_en) begin
      spur_t++;
      if (spur_t % 7 == 3) begin
        adc_done = 1'b1;
        adc_data = 12'hABC;
      end
    end
  endtask

  initial begin
    adc_done = 1'b0;
    adc_data = '0;
    forever begin
      @(negedge clk);
      monitor();
      adc_model();
    end
  end

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic setup(input int h, input int g, input int ig, input int l,
                       input bit sp);
    H = h; N = g + ig; lat = l; spur_en = sp;
    cfg_half = 8'(h); cfg_gap = 12'(g); cfg_integ = 12'(ig);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic single_frame(input int h, input int g, input int ig,
                              input int l, input bit sp, input string tag);
    int f0;
    setup(h, g, ig, l, sp);
    cfg_cont = 1'b0;
    f0 = frames;
    tick();
    pulse_start();
    while (busy || frames == f0) tick();
    repeat (20) tick();
    chk(frames == f0 + 1 && !busy, tag, "single frame count", frames - f0, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_cont = 1'b0;
    setup(2, 0, 0, 0, 0);
    repeat (3) tick();
    chk(!sen_clk && !sen_si && !adc_start && !pix_valid && !done && !busy,
        "R1", "outputs in reset", int'(busy), 0);
    rst_n = 1'b1;
    tick();
    chk(!sen_clk && !sen_si && !adc_start && !pix_valid && !done && !busy,
        "R1", "outputs after release", int'(sen_clk), 0);
    repeat (3) tick();

    single_frame(2, 3, 0, 0, 0, "R10");
    single_frame(3, 0, 5, 2, 1, "R6");
    single_frame(5, 1, 1, 3, 0, "R2");

    // R10: start pulsed mid-frame must not queue another frame
    begin
      int f0;
      setup(4, 2, 0, 1, 1);
      cfg_cont = 1'b0;
      f0 = frames;
      pulse_start();
      repeat (300) tick();
      pulse_start();
      while (busy) tick();
      repeat (60) tick();
      chk(frames == f0 + 1 && !busy && !sen_si, "R10", "start while busy ignored",
          frames - f0, 1);
    end

    // R11: continuous run, then stop after the third frame
    begin
      int f0;
      setup(4, 2, 1, 1, 0);
      cfg_cont = 1'b1;
      f0 = frames;
      pulse_start();
      while (frames < f0 + 3) tick();
      cfg_cont = 1'b0;
      while (busy) tick();
      repeat (60) tick();
      chk(frames == f0 + 3 && !busy, "R11", "continuous frame count",
          frames - f0, 3);
    end

    // R11: continuous with minimal gap and narrow clock
    begin
      int f0;
      setup(2, 1, 0, 0, 1);
      cfg_cont = 1'b1;
      f0 = frames;
      pulse_start();
      while (frames < f0 + 2) tick();
      cfg_cont = 1'b0;
      while (busy) tick();
      repeat (30) tick();
      chk(frames == f0 + 2, "R11", "short continuous run", frames - f0, 2);
    end

    chk(beat_total == served, "R7", "beats equal served samples", beat_total, served);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: got %0d frames expected completion", frames);
    summary();
    $finish;
  end

endmodule